// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns an asynchronous serial line into parallel words. An external oversampling strobe (`tick_i`) fires a fixed number of times per bit period; the receiver counts only on those strobes. It finds the falling edge of a start bit and confirms it half a bit later. It then samples each data bit, the optional parity bit and the stop bit or bits at the centre of their bit periods. Data bits arrive least significant bit first. The frame format is set by input pins and must be held steady while a frame is being received.

Every completed frame is written into a small show-ahead FIFO along with its own framing-error, parity-error and break flags. The status outputs therefore always describe the word on `data_o`, and a pop moves both the data and the flags on to the next word. A sticky overrun flag records that a finished frame found no free slot and was dropped. A pop request clears it. When the receiver is disabled it does not watch the line, and any frame in progress is abandoned.

Top module: `serial_frame_receiver`

## Requirements
- R1: After reset `avail_o`, `overrun_o`, `frm_err_o`, `par_err_o` and `brk_o` are all 0.
- R2: `word_len_i` selects the number of data bits: code 0 means 5, 1 means 6, 2 means 7 and 3 means 8. Bits are received least significant first, and `data_o` bits above the chosen length read 0.
- R3: With `par_en_i`=1 a parity bit follows the data. `par_even_i`=1 selects even parity and 0 selects odd parity. `par_err_o` is 1 for a word whose data and parity bits together have the wrong count of ones, and it is always 0 when `par_en_i`=0.
- R4: `stop2_i`=0 selects one stop bit and 1 selects two. `frm_err_o` is 1 for a word in which any stop bit was sampled low.
- R5: A low level on the line is accepted as a start bit only if it is still low half a bit period after the falling edge. A shorter low pulse produces no word.
- R6: Words leave the FIFO in arrival order. Each word carries its own flags, and a pop (`rd_i`=1 for one cycle) moves data and flags together to the next word. A pop on an empty FIFO has no effect.
- R7: `avail_o` is 1 exactly when the FIFO holds at least one word. While it is 0, the data and flag outputs read 0.
- R8: A frame that completes while the FIFO is full and no pop happens in that cycle is dropped and sets `overrun_o`. A frame that completes in the same cycle as a pop on a full FIFO is stored and sets no overrun. Any pop clears `overrun_o`.
- R9: A frame whose data, parity and stop bits were all sampled low sets `brk_o` for that word, together with `frm_err_o`.
- R10: While `rx_en_i`=0 the receiver ignores the line and returns to idle, so no word is stored. A frame cut short by disabling is lost, and reception works normally once enabled again.
- R11: Bit timing advances only on cycles with `tick_i`=1. A slower strobe stretches the bit period in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling strobe, OSR strobes per bit |
| rx_en_i | input | 1 | Receiver enable |
| rx_line_i | input | 1 | Serial input, idle high |
| word_len_i | input | 2 | Data bit count code (5 + code) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop2_i | input | 1 | 1 = two stop bits |
| rd_i | input | 1 | Pop the head word |
| avail_o | output | 1 | FIFO not empty |
| data_o | output | 8 | Head word data |
| frm_err_o | output | 1 | Head word framing error |
| par_err_o | output | 1 | Head word parity error |
| brk_o | output | 1 | Head word is a break |
| overrun_o | output | 1 | Sticky: a word was dropped |

## Verification
A frame can complete in the same cycle as a pop on a full FIFO. That is when storing the new word, raising overrun and clearing overrun all meet. The bench first measures how many cycles pass from the start bit to the cycle in which a word shows up on an empty FIFO. It then fills the FIFO and issues the pop one cycle before, exactly in, and one cycle after the completing cycle. For each case it judges the overrun flag seen in the completing cycle and which words are left when the FIFO is drained. Pops before or in that cycle must keep the new word with no overrun. A pop after it must leave overrun raised for one cycle and the new word lost.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int SRX_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } srx_state_e;

  typedef struct packed {
    logic                  brk;
    logic                  par_err;
    logic                  frm_err;
    logic [SRX_DATA_W-1:0] data;
  } srx_word_t;

  // index of the last data bit for a length code (code 0 -> 5 bits)
  function automatic logic [2:0] srx_last_index(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // parity check: even wants an even count of ones over data and parity bit
  function automatic logic srx_parity_bad(input logic [SRX_DATA_W-1:0] d,
                                          input logic pbit,
                                          input logic even);
    return (^d) ^ pbit ^ ~even;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   en_i,
  input  logic                   line_i,
  input  logic [1:0]             word_len_i,
  input  logic                   par_en_i,
  input  logic                   par_even_i,
  input  logic                   stop2_i,
  output logic                   word_valid_o,
  output srx_word_t              word_o,
  output logic                   sample_stb_o,
  output srx_state_e             state_o,
  output logic [$clog2(OSR)-1:0] os_cnt_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OSR - 1);

  srx_state_e            state;
  logic [CNT_W-1:0]      os_cnt;
  logic [2:0]            bit_idx;
  logic [SRX_DATA_W-1:0] shreg;
  logic                  pbit;
  logic                  frm_acc;
  logic                  zero_acc;
  logic                  stop_idx;
  logic                  line_q;
  logic [CNT_W-1:0]      target;
  logic                  frm_next;
  logic                  zero_next;
  logic                  last_stop;

  assign target       = (state == ST_START) ? HALF_CNT : FULL_CNT;
  assign sample_stb_o = en_i && tick_i && (state != ST_IDLE) && (os_cnt == target);
  assign frm_next     = frm_acc | ~line_i;
  assign zero_next    = zero_acc & ~line_i;
  assign last_stop    = !stop2_i || stop_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      os_cnt       <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      pbit         <= 1'b0;
      frm_acc      <= 1'b0;
      zero_acc     <= 1'b1;
      stop_idx     <= 1'b0;
      line_q       <= 1'b1;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      line_q       <= line_i;
      if (!en_i) begin
        state  <= ST_IDLE;
        os_cnt <= '0;
      end else begin
        if (state != ST_IDLE && tick_i) begin
          os_cnt <= sample_stb_o ? '0 : os_cnt + 1'b1;
        end
        case (state)
          ST_IDLE: begin
            if (line_q && !line_i) begin
              state  <= ST_START;
              os_cnt <= '0;
            end
          end
          ST_START: begin
            if (sample_stb_o) begin
              if (!line_i) begin
                state    <= ST_DATA;
                bit_idx  <= '0;
                shreg    <= '0;
                pbit     <= 1'b0;
                frm_acc  <= 1'b0;
                zero_acc <= 1'b1;
                stop_idx <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_DATA: begin
            if (sample_stb_o) begin
              shreg[bit_idx] <= line_i;
              zero_acc       <= zero_next;
              if (bit_idx == srx_last_index(word_len_i)) begin
                state <= par_en_i ? ST_PAR : ST_STOP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          ST_PAR: begin
            if (sample_stb_o) begin
              pbit     <= line_i;
              zero_acc <= zero_next;
              state    <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (sample_stb_o) begin
              frm_acc  <= frm_next;
              zero_acc <= zero_next;
              if (last_stop) begin
                word_valid_o   <= 1'b1;
                word_o.data    <= shreg;
                word_o.frm_err <= frm_next;
                word_o.par_err <= par_en_i && srx_parity_bad(shreg, pbit, par_even_i);
                word_o.brk     <= zero_next;
                state          <= ST_IDLE;
              end else begin
                stop_idx <= 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o  = state;
  assign os_cnt_o = os_cnt;
endmodule

// File: rtl/srx_word_fifo.sv
module srx_word_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  srx_word_t                wdata_i,
  input  logic                     pop_i,
  output srx_word_t                head_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic                     ovr_evt_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  srx_word_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (count == '0);
  assign full_o    = (count == CNT_W'(DEPTH));
  assign pop_ok    = pop_i && !empty_o;
  assign push_ok   = push_i && (!full_o || pop_i);
  assign ovr_evt_o = push_i && full_o && !pop_i;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count;
endmodule

// File: rtl/serial_frame_receiver.sv
module serial_frame_receiver
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rx_en_i,
  input  logic       rx_line_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       stop2_i,
  input  logic       rd_i,
  output logic       avail_o,
  output logic [7:0] data_o,
  output logic       frm_err_o,
  output logic       par_err_o,
  output logic       brk_o,
  output logic       overrun_o
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int FCNT_W = $clog2(DEPTH + 1);

  logic              line_sync;
  logic              word_valid;
  srx_word_t         new_word;
  srx_word_t         head;
  logic              sample_stb;
  srx_state_e        fsm_state;
  logic [CNT_W-1:0]  os_cnt;
  logic              fifo_empty;
  logic              fifo_full;
  logic              ovr_evt;
  logic [FCNT_W-1:0] fifo_count;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_line_i),
    .q_o   (line_sync)
  );

  srx_deframer #(.OSR(OSR)) u_deframer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .en_i         (rx_en_i),
    .line_i       (line_sync),
    .word_len_i   (word_len_i),
    .par_en_i     (par_en_i),
    .par_even_i   (par_even_i),
    .stop2_i      (stop2_i),
    .word_valid_o (word_valid),
    .word_o       (new_word),
    .sample_stb_o (sample_stb),
    .state_o      (fsm_state),
    .os_cnt_o     (os_cnt)
  );

  srx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (word_valid),
    .wdata_i   (new_word),
    .pop_i     (rd_i),
    .head_o    (head),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full),
    .ovr_evt_o (ovr_evt),
    .count_o   (fifo_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun_o <= 1'b0;
    else if (ovr_evt) overrun_o <= 1'b1;
    else if (rd_i)    overrun_o <= 1'b0;
  end

  assign avail_o   = !fifo_empty;
  assign data_o    = avail_o ? head.data : '0;
  assign frm_err_o = avail_o && head.frm_err;
  assign par_err_o = avail_o && head.par_err;
  assign brk_o     = avail_o && head.brk;
endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import srx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en_i,
  input logic                       tick_i,
  input logic                       rd_i,
  input logic                       avail_o,
  input logic                       overrun_o,
  input logic                       word_valid,
  input srx_word_t                  new_word,
  input logic                       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       sample_stb,
  input srx_state_e                 fsm_state,
  input logic [CNT_W-1:0]           os_cnt
);
  // R8: a word completing on a full FIFO with no pop raises overrun
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && fifo_full && !rd_i) |=> overrun_o);

  // R8: a pop always leaves overrun low (a pop on full accepts the word)
  a_r8_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !overrun_o);

  // R9: a break word always carries a framing error
  a_r9_break_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && new_word.brk) |-> new_word.frm_err);

  // R10: no word is produced after a disabled cycle
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en_i) |-> !word_valid);

  // R7: popping the only word with nothing arriving empties the FIFO
  a_r7_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == 1 && rd_i && !word_valid) |=> !avail_o);

  // R11: the bit-time counter holds on cycles without a strobe
  a_r11_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && !tick_i && fsm_state == ST_DATA) |=> $stable(os_cnt));

  // R11: a centre sample never happens without a strobe
  a_r11_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tick_i);

  // R6: occupancy never exceeds the FIFO depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind serial_frame_receiver srx_checker #(.DEPTH(DEPTH), .CNT_W($clog2(OSR))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en_i    (rx_en_i),
  .tick_i     (tick_i),
  .rd_i       (rd_i),
  .avail_o    (avail_o),
  .overrun_o  (overrun_o),
  .word_valid (word_valid),
  .new_word   (new_word),
  .fifo_full  (fifo_full),
  .fifo_count (fifo_count),
  .sample_stb (sample_stb),
  .fsm_state  (fsm_state),
  .os_cnt     (os_cnt)
);

// File: tb/serial_frame_receiver_tb.sv
module serial_frame_receiver_tb;
  localparam int OSR   = 16;
  localparam int DEPTH = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       rx_en = 0;
  logic       line = 1;
  logic       rd = 0;
  logic [1:0] wl = 2'd3;
  logic       pe = 0;
  logic       pev = 0;
  logic       st2 = 0;
  logic       avail, frm, par, brk, ovr;
  logic [7:0] data;

  int div = 1;
  int tph = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick = ((tph % div) == 0);
    tph  = tph + 1;
  end

  serial_frame_receiver #(.OSR(OSR), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_en_i(rx_en), .rx_line_i(line),
    .word_len_i(wl), .par_en_i(pe), .par_even_i(pev), .stop2_i(st2), .rd_i(rd),
    .avail_o(avail), .data_o(data), .frm_err_o(frm), .par_err_o(par),
    .brk_o(brk), .overrun_o(ovr)
  );

  task automatic chk(input string m, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", m, a, e);
    end
  endtask

  task automatic drive_bit(input logic b);
    line = b;
    repeat (OSR * div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit bk);
    int   nb = 5 + int'(wl);
    int   ones = 0;
    logic pb;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      drive_bit(bk ? 1'b0 : d[i]);
      ones += int'(d[i]);
    end
    pb = (((ones % 2) == 1) ^ !pev) ^ bad_par;
    if (pe) drive_bit(bk ? 1'b0 : pb);
    if (st2) drive_bit(bk ? 1'b0 : 1'b1);
    drive_bit((bk || bad_stop) ? 1'b0 : 1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pop();
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
  endtask

  task automatic expect_word(input string tag, input logic [7:0] d,
                             input bit bp, input bit bs, input bit bk);
    int         nb = 5 + int'(wl);
    logic [7:0] m  = 8'((1 << nb) - 1);
    chk({tag, " R7 avail"}, avail, 1);
    chk({tag, " R2 data"}, data, bk ? 8'h00 : (d & m));
    chk({tag, " R4 frm"}, frm, bs | bk);
    chk({tag, " R3 par"}, par, pe & (bp | (bk & !pev)));
    chk({tag, " R9 brk"}, brk, bk);
    pop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int   p;
    logic ovr_seen;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 avail", avail, 0);
    chk("R1 overrun", ovr, 0);
    chk("R1 flags", {frm, par, brk}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rx_en = 1;
    repeat (OSR) @(negedge clk);

    // R2 R3 R4 R6 sweep over every frame format, two words each
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int s = 0; s < 2; s++) begin
          logic [7:0] d1;
          wl  = 2'(w);
          pe  = (pm != 0);
          pev = (pm == 2);
          st2 = s[0];
          d1  = 8'hA5 ^ 8'(w * 16 + pm * 4 + s);
          send(d1, 0, 0, 0);
          send(~d1, 0, 0, 0);
          expect_word("R6 first", d1, 0, 0, 0);
          expect_word("R6 second", ~d1, 0, 0, 0);
          chk("R7 empty after drain", avail, 0);
        end
      end
    end

    // R3 corrupted parity, both senses; R6 flags follow their own word
    wl = 2'd3; pe = 1; st2 = 0;
    pev = 1; send(8'h3C, 1, 0, 0); send(8'h3D, 0, 0, 0);
    expect_word("R3 even bad", 8'h3C, 1, 0, 0);
    expect_word("R6 clean after bad", 8'h3D, 0, 0, 0);
    pev = 0; send(8'h81, 1, 0, 0);
    expect_word("R3 odd bad", 8'h81, 1, 0, 0);

    // R4 second stop bit low; single stop low
    pe = 0; st2 = 1; send(8'h5E, 0, 1, 0);
    expect_word("R4 second stop", 8'h5E, 0, 1, 0);
    st2 = 0; wl = 2'd1; send(8'h2B, 0, 1, 0);
    expect_word("R4 one stop", 8'h2B, 0, 1, 0);

    // R9 break with and without odd parity
    wl = 2'd3; send(8'h00, 0, 0, 1);
    expect_word("R9 break", 8'h00, 0, 0, 1);
    pe = 1; pev = 0; send(8'h00, 0, 0, 1);
    expect_word("R9 break odd", 8'h00, 0, 0, 1);
    pe = 0;

    // R5 short low pulse is rejected
    line = 0; repeat (OSR / 4) @(negedge clk);
    line = 1; repeat (3 * OSR) @(negedge clk);
    chk("R5 glitch ignored", avail, 0);

    // R10 disabled throughout, then cut mid-frame, then normal
    rx_en = 0; send(8'h6A, 0, 0, 0);
    chk("R10 disabled no word", avail, 0);
    rx_en = 1;
    fork
      send(8'hC3, 0, 0, 0);
      begin repeat (4 * OSR) @(negedge clk); rx_en = 0; end
    join
    rx_en = 1; repeat (OSR) @(negedge clk);
    chk("R10 cut frame lost", avail, 0);
    send(8'h96, 0, 0, 0);
    expect_word("R10 recovers", 8'h96, 0, 0, 0);

    // R11 half-rate strobe
    div = 2; wl = 2'd2; pe = 1; pev = 1;
    send(8'h4D, 0, 0, 0);
    expect_word("R11 half tick", 8'h4D, 0, 0, 0);
    div = 1; pe = 0; wl = 2'd3;
    repeat (OSR) @(negedge clk);

    // R8 calibrate completion latency on an empty FIFO
    p = 0;
    fork
      send(8'h5A, 0, 0, 0);
      begin
        while (!avail && p < 1000) begin @(negedge clk); p++; end
      end
    join
    expect_word("R8 calibration", 8'h5A, 0, 0, 0);

    // R8 pop before, in, and after the completing cycle on a full FIFO
    for (int off = p - 2; off <= p; off++) begin
      for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), 0, 0, 0);
      chk("R8 no overrun when filled", ovr, 0);
      ovr_seen = 0;
      fork
        send(8'h77, 0, 0, 0);
        begin repeat (off) @(negedge clk); rd = 1; @(negedge clk); rd = 0; end
        begin repeat (p) @(negedge clk); ovr_seen = ovr; end
      join
      chk($sformatf("R8 overrun at completion off=%0d", off - p), ovr_seen, (off == p));
      chk("R8 overrun cleared by pop", ovr, 0);
      for (int i = 1; i < DEPTH; i++) expect_word("R8 drain", 8'h10 + 8'(i), 0, 0, 0);
      if (off < p) expect_word("R8 new word kept", 8'h77, 0, 0, 0);
      chk("R8 drained", avail, 0);
    end

    // R6 pop on empty FIFO has no effect
    pop();
    chk("R6 empty pop", avail, 0);
    send(8'hE1, 0, 0, 0);
    expect_word("R6 after empty pop", 8'hE1, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule